// File: doc/BRIEF.md
# Paged Program Counter with Return-Address Stack

This block keeps the instruction address of a small processor core whose call instruction carries an 11-bit target, while the code space is 13 bits wide. It steps the address by one for each ordinary instruction. On a call it saves the address of the following instruction on a hardware return stack and builds the new address. The low 11 bits come from the instruction literal and the top two bits come from a 5-bit page register that software writes beforehand. On a return it reloads the full address from the top of the stack.

A taken call or return costs two instruction cycles. In the cycle after the jump the block raises a flush output, so that the instruction fetched in the meantime is thrown away. While flush is high, every strobe and page-register write is ignored. The stack is a circular buffer of eight entries. Overflow and underflow wrap silently and are not signalled.

Top module: `paged_pc`

## Requirements
- R1: After reset, `pc_o` is 0, `page_o` is 0 and `flush_o` is 0.
- R2: An accepted cycle with only `adv_i` high sets `pc_o` to the old value plus one, modulo 8192, at the next clock edge.
- R3: An accepted call (`call_i` high) sets `pc_o[10:0]` to `lit_i` and `pc_o[12:11]` to `page_o[4:3]` at the next clock edge.
- R4: `flush_o` is high for exactly the one cycle following an accepted call or return. During that cycle all strobes and page writes are ignored, and `pc_o` and `page_o` hold.
- R5: An accepted return (`ret_i` high, `call_i` low) loads `pc_o` with the most recently pushed, not yet popped, return address, and then removes it. A call pushes the old `pc_o` plus one, modulo 8192.
- R6: The stack holds 8 entries and wraps. After nine calls with no return in between, the first eight returns give the pushed addresses from the ninth back to the second. The ninth return gives the ninth address again.
- R7: An accepted write (`page_we_i` high) makes `page_o` equal `page_wd_i` at the next edge. A call in the same cycle uses the page value from before the write.
- R8: Strobe priority is call over return over advance. In an accepted cycle with no strobe high, `pc_o` holds.
- R9: A call taken at `pc_o` = 8191 pushes the return address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Instruction-cycle clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| adv_i | input | 1 | Step to the next sequential instruction |
| call_i | input | 1 | Take a subroutine call |
| ret_i | input | 1 | Return from a subroutine |
| lit_i | input | 11 | Call target literal (low address bits) |
| page_we_i | input | 1 | Page register write enable |
| page_wd_i | input | 5 | Page register write data |
| pc_o | output | 13 | Current instruction address |
| page_o | output | 5 | Current page register value |
| flush_o | output | 1 | Discard the instruction fetched during this cycle |

## Verification
The assertions check on every cycle the step-by-one rule, the call target built from the literal and the page bits, the single-cycle flush after each jump, the hold of both registers while flushing, the idle hold and the page write. Only the bench's scenarios can show that the stack returns the right addresses in last-in, first-out order. The same is true of the silent wrap on a ninth push and of the return address wrapping at the top of the code space. The bench also sweeps every literal under every page value and every page register value.

// File: rtl/paged_pc_pkg.sv
package paged_pc_pkg;
   typedef enum logic [1:0] {
      OP_HOLD = 2'd0,
      OP_STEP = 2'd1,
      OP_CALL = 2'd2,
      OP_RET  = 2'd3
   } pc_op_e;

   function automatic logic op_is_jump(pc_op_e op);
      return (op == OP_CALL) || (op == OP_RET);
   endfunction
endpackage

// File: rtl/paged_pc_decode.sv
module paged_pc_decode
   import paged_pc_pkg::*;
(
   input  logic   squash_i,
   input  logic   adv_i,
   input  logic   call_i,
   input  logic   ret_i,
   input  logic   we_i,
   output pc_op_e op_o,
   output logic   we_o
);
   always_comb begin
      op_o = OP_HOLD;
      if (!squash_i) begin
         if (call_i)      op_o = OP_CALL;
         else if (ret_i)  op_o = OP_RET;
         else if (adv_i)  op_o = OP_STEP;
      end
   end

   assign we_o = we_i && !squash_i;
endmodule

// File: rtl/paged_pc_page.sv
module paged_pc_page #(
   parameter int unsigned REG_W    = 5,
   parameter int unsigned SEL_LSB  = 3,
   parameter int unsigned SEL_W    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_i,
   input  logic [REG_W-1:0] wd_i,
   output logic [REG_W-1:0] val_o,
   output logic [SEL_W-1:0] sel_o
);
   localparam int unsigned SEL_MSB = SEL_LSB + SEL_W - 1;

   if (SEL_MSB >= REG_W) begin : g_bad_sel
      $error("page select field exceeds page register");
   end

   logic [REG_W-1:0] val_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    val_q <= '0;
      else if (we_i) val_q <= wd_i;
   end

   assign val_o = val_q;
   assign sel_o = val_q[SEL_MSB:SEL_LSB];
endmodule

// File: rtl/paged_pc_stack.sv
module paged_pc_stack #(
   parameter int unsigned DW    = 13,
   parameter int unsigned DEPTH = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push_i,
   input  logic          pop_i,
   input  logic [DW-1:0] push_d_i,
   output logic [DW-1:0] top_o
);
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (DEPTH < 1 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("stack depth must be a power of two");
   end

   logic [DW-1:0] slot_q [DEPTH];

   if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      slot_q[0] <= '0;
         else if (push_i) slot_q[0] <= push_d_i;
      end
      assign top_o = slot_q[0];
   end else begin : g_ring
      logic [PTR_W-1:0] wr_q;
      logic [PTR_W-1:0] rd_idx;

      assign rd_idx = wr_q - 1'b1;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wr_q <= '0;
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
         end else if (push_i) begin
            slot_q[wr_q] <= push_d_i;
            wr_q         <= wr_q + 1'b1;
         end else if (pop_i) begin
            wr_q <= rd_idx;
         end
      end

      assign top_o = slot_q[rd_idx];
   end
endmodule

// File: rtl/paged_pc.sv
module paged_pc
   import paged_pc_pkg::*;
#(
   parameter int unsigned PC_W     = 13,
   parameter int unsigned LIT_W    = 11,
   parameter int unsigned PAGE_W   = 5,
   parameter int unsigned PAGE_LSB = 3,
   parameter int unsigned DEPTH    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv_i,
   input  logic              call_i,
   input  logic              ret_i,
   input  logic [LIT_W-1:0]  lit_i,
   input  logic              page_we_i,
   input  logic [PAGE_W-1:0] page_wd_i,
   output logic [PC_W-1:0]   pc_o,
   output logic [PAGE_W-1:0] page_o,
   output logic              flush_o
);
   localparam int unsigned SEL_W = PC_W - LIT_W;

   if (LIT_W >= PC_W) begin : g_bad_width
      $error("literal must be narrower than the counter");
   end

   pc_op_e           op;
   logic             we_ok;
   logic [SEL_W-1:0] sel;
   logic [PC_W-1:0]  pc_q;
   logic [PC_W-1:0]  pc_inc;
   logic [PC_W-1:0]  pc_nxt;
   logic [PC_W-1:0]  top;
   logic             flush_q;

   paged_pc_decode u_dec (
      .squash_i (flush_q),
      .adv_i    (adv_i),
      .call_i   (call_i),
      .ret_i    (ret_i),
      .we_i     (page_we_i),
      .op_o     (op),
      .we_o     (we_ok)
   );

   paged_pc_page #(
      .REG_W   (PAGE_W),
      .SEL_LSB (PAGE_LSB),
      .SEL_W   (SEL_W)
   ) u_page (
      .clk   (clk),
      .rst_n (rst_n),
      .we_i  (we_ok),
      .wd_i  (page_wd_i),
      .val_o (page_o),
      .sel_o (sel)
   );

   paged_pc_stack #(
      .DW    (PC_W),
      .DEPTH (DEPTH)
   ) u_stk (
      .clk      (clk),
      .rst_n    (rst_n),
      .push_i   (op == OP_CALL),
      .pop_i    (op == OP_RET),
      .push_d_i (pc_inc),
      .top_o    (top)
   );

   assign pc_inc = pc_q + 1'b1;

   always_comb begin
      unique case (op)
         OP_STEP: pc_nxt = pc_inc;
         OP_CALL: pc_nxt = {sel, lit_i};
         OP_RET:  pc_nxt = top;
         default: pc_nxt = pc_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q    <= '0;
         flush_q <= 1'b0;
      end else begin
         pc_q    <= pc_nxt;
         flush_q <= op_is_jump(op);
      end
   end

   assign pc_o    = pc_q;
   assign flush_o = flush_q;
endmodule

// File: rtl/paged_pc_chk.sv
module paged_pc_chk #(
   parameter int unsigned PC_W     = 13,
   parameter int unsigned LIT_W    = 11,
   parameter int unsigned PAGE_W   = 5,
   parameter int unsigned PAGE_LSB = 3,
   parameter int unsigned DEPTH    = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              adv_i,
   input logic              call_i,
   input logic              ret_i,
   input logic [LIT_W-1:0]  lit_i,
   input logic              page_we_i,
   input logic [PAGE_W-1:0] page_wd_i,
   input logic [PC_W-1:0]   pc_o,
   input logic [PAGE_W-1:0] page_o,
   input logic              flush_o
);
   localparam int unsigned SEL_W = PC_W - LIT_W;

   AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush_o && adv_i && !call_i && !ret_i) |=> (pc_o == $past(pc_o) + 1'b1)); // R2

   AST_CALL_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush_o && call_i) |=> (pc_o == {$past(page_o[PAGE_LSB +: SEL_W]), $past(lit_i)})); // R3

   AST_FLUSH_AFTER_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush_o && (call_i || ret_i)) |=> flush_o); // R4

   AST_FLUSH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      flush_o |=> !flush_o); // R4

   AST_FLUSH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      flush_o |=> ($stable(pc_o) && $stable(page_o))); // R4

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush_o && !adv_i && !call_i && !ret_i) |=> ($stable(pc_o) && !flush_o)); // R8

   AST_PAGE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush_o && page_we_i) |=> (page_o == $past(page_wd_i))); // R7

   AST_PAGE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!page_we_i) |=> $stable(page_o)); // R7
endmodule

bind paged_pc paged_pc_chk #(
   .PC_W     (PC_W),
   .LIT_W    (LIT_W),
   .PAGE_W   (PAGE_W),
   .PAGE_LSB (PAGE_LSB),
   .DEPTH    (DEPTH)
) u_chk (.*);

// File: tb/tb_paged_pc.sv
module tb_paged_pc;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        adv_i = 1'b0, call_i = 1'b0, ret_i = 1'b0, page_we_i = 1'b0;
   logic [10:0] lit_i = '0;
   logic [4:0]  page_wd_i = '0;
   logic [12:0] pc_o;
   logic [4:0]  page_o;
   logic        flush_o;

   int checks = 0;
   int failures = 0;

   logic [12:0] e_pc;
   logic [4:0]  e_pg;
   logic        e_fl;
   logic [12:0] e_stk [8];
   int          e_ptr;

   paged_pc dut (.*);

   always #4 clk = ~clk;

   initial begin
      #1600000;
      failures++;
      $display("FAIL watchdog: run did not end (actual hung, expected done)");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic cmp(string tag);
      check(tag, pc_o, e_pc, "pc");
      check(tag, page_o, e_pg, "page");
      check(tag, flush_o, e_fl, "flush");
   endtask

   task automatic step(string tag, bit c, bit r, bit a, logic [10:0] l, bit w, logic [4:0] d);
      @(negedge clk);
      call_i = c; ret_i = r; adv_i = a; lit_i = l; page_we_i = w; page_wd_i = d;
      @(posedge clk);
      #1;
      if (e_fl) begin
         e_fl = 1'b0;
      end else begin
         if (c) begin
            e_stk[e_ptr] = e_pc + 13'd1;
            e_ptr = (e_ptr + 1) % 8;
            e_pc = {e_pg[4:3], l};
            e_fl = 1'b1;
         end else if (r) begin
            e_ptr = (e_ptr + 7) % 8;
            e_pc = e_stk[e_ptr];
            e_fl = 1'b1;
         end else if (a) begin
            e_pc = e_pc + 13'd1;
         end
         if (w) e_pg = d;
      end
      cmp(tag);
   endtask

   initial begin
      logic [12:0] pushed [9];
      e_pc = '0; e_pg = '0; e_fl = 1'b0; e_ptr = 0;
      for (int i = 0; i < 8; i++) e_stk[i] = '0;
      repeat (3) @(posedge clk);
      #1;
      cmp("R1");
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      cmp("R1");

      // R2: full sweep of the counter, including the wrap to 0
      for (int i = 0; i < 8192; i++) step("R2", 0, 0, 1, '0, 0, '0);
      check("R2", pc_o, 0, "pc after full wrap");

      // R7: every page register value
      for (int v = 0; v < 32; v++) step("R7", 0, 0, 0, '0, 1, v[4:0]);

      // R3 / R4 / R5: every literal under every page value
      for (int pg = 0; pg < 4; pg++) begin
         step("R7", 0, 0, 0, '0, 1, 5'(pg * 8 + (pg ^ 5)));
         for (int l = 0; l < 2048; l++) begin
            logic [12:0] ret_to;
            ret_to = e_pc + 13'd1;
            step("R3", 1, 0, 0, l[10:0], 0, '0);
            check("R3", pc_o, (pg << 11) | l, "call target");
            step("R4", 1, 1, 1, ~l[10:0], 1, 5'h1f);
            step("R5", 0, 1, 0, '0, 0, '0);
            check("R5", pc_o, ret_to, "return address");
            step("R4", 1, 0, 1, l[10:0], 1, 5'h00);
            if (l % 97 == 0) step("R2", 0, 0, 1, '0, 0, '0);
         end
      end

      // R6: nine nested calls, then nine returns
      step("R7", 0, 0, 0, '0, 1, 5'b01000);
      for (int i = 0; i < 9; i++) begin
         pushed[i] = e_pc + 13'd1;
         step("R6", 1, 0, 0, 11'(i * 37 + 5), 0, '0);
         step("R6", 0, 0, 0, '0, 0, '0);
         step("R6", 0, 0, 1, '0, 0, '0);
      end
      for (int i = 0; i < 9; i++) begin
         step("R6", 0, 1, 0, '0, 0, '0);
         check("R6", pc_o, (i < 8) ? pushed[8 - i] : pushed[8], "nested return");
         step("R6", 0, 0, 0, '0, 0, '0);
      end

      // R8: priority and idle hold
      step("R8", 1, 1, 1, 11'h123, 0, '0);
      check("R8", pc_o, 13'h0923, "call wins");
      step("R8", 0, 0, 0, '0, 0, '0);
      step("R8", 0, 1, 1, '0, 0, '0);
      step("R8", 0, 0, 0, '0, 0, '0);
      for (int i = 0; i < 4; i++) step("R8", 0, 0, 0, '0, 0, '0);

      // R7: write and call in the same cycle use the old page
      step("R7", 0, 0, 0, '0, 1, 5'b11000);
      step("R7", 1, 0, 0, 11'h055, 1, 5'b00000);
      check("R7", pc_o, 13'h1855, "call uses old page");
      step("R7", 0, 0, 0, '0, 0, '0);
      check("R7", page_o, 0, "page after write");

      // R9: call from the top address
      step("R9", 0, 0, 0, '0, 1, 5'b11000);
      step("R9", 1, 0, 0, 11'h7ff, 0, '0);
      step("R9", 0, 0, 0, '0, 0, '0);
      check("R9", pc_o, 13'h1fff, "at top");
      step("R9", 1, 0, 0, 11'h010, 0, '0);
      step("R9", 0, 0, 0, '0, 0, '0);
      step("R9", 0, 1, 0, '0, 0, '0);
      check("R9", pc_o, 0, "wrapped return address");
      step("R9", 0, 0, 0, '0, 0, '0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule